// File: doc/BRIEF.md
# LIN Bit-Rate Tick Generator

This block derives a bit-rate strobe for a LIN-style serial link from the system clock. Three counting stages run in series. A power-of-two prescaler divides by 2^(p+1). An integer stage then divides by m+1. A 9-bit divider divides by d. The output `tick` is high for one clock at the end of each full period, so the period is 2^(p+1)·(m+1)·d clocks. For example, with p=1, m=0 and d=312, a 24 MHz clock gives 1248 clocks per tick, which is about 19230.77 ticks per second.

Software programs the stages through an indirect register port. An address write selects an internal register. Data writes then update the selected register. A data read copies the selected register to `rdata` on the next clock edge. Writing the rate-field registers restarts the counter chain, so a new rate starts cleanly from a known phase. A control register holds the run enable.

Top module: `lin_tick_gen`

## Requirements
- R1: While enabled and not reprogrammed, `tick` rises once every 2^(p+1)·(m+1)·d clocks, where p, m and d are the programmed prescaler, multiplier and divider values.
- R2: `tick` is never high for two consecutive clocks.
- R3: The rate register at index 0x0D holds the prescaler p in bits 7:6, the multiplier m in bits 5:1, and divider bit 8 in bit 0. It reads back exactly what was written.
- R4: The register at index 0x0C holds divider bits 7:0 and reads back exactly what was written.
- R5: Bit 0 of the control register at index 0x0E enables the counters. While it is 0, no tick occurs. After it is written to 1, the first tick comes exactly one full period after that write's clock edge.
- R6: A data write to index 0x0C or 0x0D restarts all stages. The first tick comes exactly one full period of the new setting after the write's clock edge, and no tick appears in the clock after the write.
- R7: A divider value of 0 gives the same period as a divider of 1.
- R8: Indices other than 0x0C, 0x0D and 0x0E read as zero, and writes to them change no register.
- R9: After reset, all fields, the address register, the enable bit and `rdata` are zero, and no tick occurs.
- R10: `rdata` is loaded only on a clock edge where `data_rd` is high. At all other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously inside the block |
| addr_we | input | 1 | Loads `wdata` into the index register |
| data_we | input | 1 | Writes `wdata` into the register selected by the index |
| data_rd | input | 1 | Copies the selected register to `rdata` on the next edge |
| wdata | input | 8 | Write data for the index and data strobes |
| rdata | output | 8 | Read data, held between reads |
| tick | output | 1 | One-clock bit-rate strobe |

## Verification
On every cycle, the bound checker confirms four things. Tick spacing matches the product of the current fields. The tick is one clock wide. A restart or a cleared enable suppresses the following tick. `rdata` moves only after a read strobe. Only the directed scenarios show the rest. These cover the exact clock count from a reprogramming or enable edge to the first tick, the bit packing of the rate fields seen through readback, the zero-divider substitution, and the fact that unused indices read zero and disturb nothing.

// File: rtl/lin_tick_pkg.sv
package lin_tick_pkg;

  localparam int REG_W   = 8;
  localparam int PRE_W   = 2;
  localparam int MUL_W   = 5;
  localparam int DIV_W   = 9;
  localparam int PRE_CW  = 2 ** PRE_W;
  localparam int N_STAGE = 3;

  localparam logic [REG_W-1:0] IDX_DIV = 8'h0C;
  localparam logic [REG_W-1:0] IDX_MUL = 8'h0D;
  localparam logic [REG_W-1:0] IDX_CTL = 8'h0E;

  function automatic int stage_w(input int i);
    case (i)
      0:       return PRE_CW;
      1:       return MUL_W;
      default: return DIV_W;
    endcase
  endfunction

  function automatic int stage_off(input int i);
    int s;
    s = 0;
    for (int k = 0; k < i; k++) s += stage_w(k);
    return s;
  endfunction

  localparam int LAST_W = stage_off(N_STAGE);

endpackage

// File: rtl/lin_tick_rstsync.sv
module lin_tick_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sh_q <= '0;
    else           sh_q <= sh_d;
  end

  assign rst_out_n = sh_q[STAGES-1];

endmodule

// File: rtl/lin_tick_regs.sv
module lin_tick_regs
  import lin_tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_we,
  input  logic             data_we,
  input  logic             data_rd,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic [PRE_W-1:0] pre_f,
  output logic [MUL_W-1:0] mul_f,
  output logic [DIV_W-1:0] div_f,
  output logic             run,
  output logic             restart
);

  logic [REG_W-1:0] idx_q,   idx_d;
  logic [PRE_W-1:0] pre_q,   pre_d;
  logic [MUL_W-1:0] mul_q,   mul_d;
  logic [DIV_W-1:0] div_q,   div_d;
  logic             run_q,   run_d;
  logic [REG_W-1:0] rdata_q, rdata_d;

  logic             sel_div, sel_mul, sel_ctl;
  logic             wr_div, wr_mul, wr_ctl;
  logic [REG_W-1:0] view_mul, view_div, view_ctl, rd_mux;

  always_comb begin
    sel_div = (idx_q == IDX_DIV);
    sel_mul = (idx_q == IDX_MUL);
    sel_ctl = (idx_q == IDX_CTL);
    wr_div  = data_we & sel_div;
    wr_mul  = data_we & sel_mul;
    wr_ctl  = data_we & sel_ctl;
  end

  always_comb begin
    view_mul = {pre_q, mul_q, div_q[DIV_W-1]};
    view_div = div_q[REG_W-1:0];
    view_ctl = {{(REG_W-1){1'b0}}, run_q};
    rd_mux   = '0;
    if (sel_mul) rd_mux = view_mul;
    if (sel_div) rd_mux = view_div;
    if (sel_ctl) rd_mux = view_ctl;
  end

  always_comb begin
    idx_d   = addr_we ? wdata : idx_q;
    pre_d   = pre_q;
    mul_d   = mul_q;
    div_d   = div_q;
    run_d   = run_q;
    rdata_d = data_rd ? rd_mux : rdata_q;
    if (wr_mul) begin
      pre_d            = wdata[REG_W-1 -: PRE_W];
      mul_d            = wdata[MUL_W:1];
      div_d[DIV_W-1]   = wdata[0];
    end
    if (wr_div) div_d[REG_W-1:0] = wdata;
    if (wr_ctl) run_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      pre_q   <= '0;
      mul_q   <= '0;
      div_q   <= '0;
      run_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      idx_q   <= idx_d;
      pre_q   <= pre_d;
      mul_q   <= mul_d;
      div_q   <= div_d;
      run_q   <= run_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata   = rdata_q;
  assign pre_f   = pre_q;
  assign mul_f   = mul_q;
  assign div_f   = div_q;
  assign run     = run_q;
  assign restart = wr_div | wr_mul;

endmodule

// File: rtl/lin_tick_stage.sv
module lin_tick_stage #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] last,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit;

  always_comb begin
    hit   = (cnt_q == last);
    wrap  = step & hit & ~clr;
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lin_tick_chain.sv
module lin_tick_chain
  import lin_tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [LAST_W-1:0] last_flat,
  output logic              tick
);

  logic [N_STAGE:0] step;
  logic             clr;
  logic             tick_q, tick_d;

  assign clr     = ~run | restart;
  assign step[0] = run;

  for (genvar i = 0; i < N_STAGE; i++) begin : g_stage
    localparam int SW  = stage_w(i);
    localparam int OFS = stage_off(i);
    lin_tick_stage #(.CNT_W(SW)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .step  (step[i]),
      .last  (last_flat[OFS +: SW]),
      .wrap  (step[i+1])
    );
  end

  always_comb begin
    tick_d = clr ? 1'b0 : step[N_STAGE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_d;
  end

  assign tick = tick_q;

endmodule

// File: rtl/lin_tick_gen.sv
module lin_tick_gen
  import lin_tick_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_we,
  input  logic             data_we,
  input  logic             data_rd,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             tick
);

  logic              rst_core_n;
  logic [PRE_W-1:0]  pre_f;
  logic [MUL_W-1:0]  mul_f;
  logic [DIV_W-1:0]  div_f;
  logic              run_q;
  logic              restart;
  logic [PRE_CW-1:0] pre_last;
  logic [MUL_W-1:0]  mul_last;
  logic [DIV_W-1:0]  div_last;
  logic [LAST_W-1:0] last_flat;

  lin_tick_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_core_n)
  );

  lin_tick_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .addr_we (addr_we),
    .data_we (data_we),
    .data_rd (data_rd),
    .wdata   (wdata),
    .rdata   (rdata),
    .pre_f   (pre_f),
    .mul_f   (mul_f),
    .div_f   (div_f),
    .run     (run_q),
    .restart (restart)
  );

  always_comb begin
    pre_last  = PRE_CW'((32'd2 << pre_f) - 32'd1);
    mul_last  = mul_f;
    div_last  = (div_f == '0) ? '0 : div_f - 1'b1;
    last_flat = {div_last, mul_last, pre_last};
  end

  lin_tick_chain u_chain (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (run_q),
    .restart   (restart),
    .last_flat (last_flat),
    .tick      (tick)
  );

endmodule

// File: rtl/lin_tick_chk.sv
module lin_tick_chk
  import lin_tick_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             restart,
  input logic             tick,
  input logic             data_rd,
  input logic [REG_W-1:0] rdata,
  input logic [PRE_W-1:0] pre,
  input logic [MUL_W-1:0] mul,
  input logic [DIV_W-1:0] div
);

  logic [31:0] gap_q;
  logic [31:0] period;

  always_comb begin
    period = (32'd2 << pre) * (32'(mul) + 32'd1) * ((div == '0) ? 32'd1 : 32'(div));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               gap_q <= '0;
    else if (!run || restart) gap_q <= '0;
    else if (tick)            gap_q <= 32'd1;
    else                      gap_q <= gap_q + 32'd1;
  end

  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == period));

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  assert_idle_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);

  assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> $stable(rdata));

endmodule

bind lin_tick_gen lin_tick_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .run     (run_q),
  .restart (restart),
  .tick    (tick),
  .data_rd (data_rd),
  .rdata   (rdata),
  .pre     (pre_f),
  .mul     (mul_f),
  .div     (div_f)
);

// File: tb/lin_tick_gen_test.sv
module lin_tick_gen_test;

  logic       clk;
  logic       rst_n;
  logic       addr_we;
  logic       data_we;
  logic       data_rd;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       tick;

  int checks;
  int errors;

  lin_tick_gen uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_we (addr_we),
    .data_we (data_we),
    .data_rd (data_rd),
    .wdata   (wdata),
    .rdata   (rdata),
    .tick    (tick)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_addr(input logic [7:0] idx);
    @(negedge clk); addr_we = 1'b1; wdata = idx;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic put_data(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic get_reg(input logic [7:0] idx, output logic [7:0] v);
    put_addr(idx);
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    v = rdata;
  endtask

  task automatic program_rate(input int p, input int m, input int d);
    logic [8:0] dv;
    dv = 9'(d);
    put_addr(8'h0D);
    put_data({2'(p), 5'(m), dv[8]});
    put_addr(8'h0C);
    put_data(dv[7:0]);
  endtask

  // called right after a write strobe: counts clocks to the first tick and one full gap
  task automatic expect_period(input int exp, input string req);
    int k;
    int j;
    bit wide;
    k = 0;
    while (k < exp + 20) begin
      @(negedge clk); k++;
      if (tick) break;
    end
    check(k == exp, req, k, exp);
    j = 0;
    wide = 1'b0;
    while (j < exp + 20) begin
      @(negedge clk); j++;
      if (j == 1 && tick) wide = 1'b1;
      if (tick && j > 1) break;
    end
    check(!wide, "R2", int'(wide), 0);
    check(j == exp, req, j, exp);
  endtask

  task automatic quiet_for(input int n, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check(rdata == 8'h00, "R9", rdata, 0);
    quiet_for(40, "R9");
    get_reg(8'h0C, v); check(v == 8'h00, "R9", v, 0);
    get_reg(8'h0D, v); check(v == 8'h00, "R9", v, 0);
    get_reg(8'h0E, v); check(v == 8'h00, "R9", v, 0);
  endtask

  task automatic t_disabled;
    program_rate(0, 0, 1);
    quiet_for(100, "R5");
  endtask

  task automatic t_enable;
    put_addr(8'h0E);
    put_data(8'h01);
    expect_period(2, "R5");
  endtask

  task automatic t_nominal;
    logic [7:0] v;
    program_rate(1, 0, 312);
    expect_period(1248, "R1");
    get_reg(8'h0D, v); check(v == 8'h41, "R3", v, 8'h41);
    get_reg(8'h0C, v); check(v == 8'h38, "R4", v, 8'h38);
  endtask

  task automatic t_max_pre;
    logic [7:0] v;
    program_rate(3, 31, 2);
    expect_period(1024, "R1");
    get_reg(8'h0D, v); check(v == 8'hFE, "R3", v, 8'hFE);
  endtask

  task automatic t_mid;
    program_rate(0, 2, 3);
    expect_period(18, "R1");
  endtask

  task automatic t_div_high;
    logic [7:0] v;
    program_rate(0, 0, 256);
    expect_period(512, "R1");
    get_reg(8'h0D, v); check(v == 8'h01, "R3", v, 8'h01);
    get_reg(8'h0C, v); check(v == 8'h00, "R4", v, 0);
  endtask

  task automatic t_zero_div;
    program_rate(0, 0, 0);
    expect_period(2, "R7");
    program_rate(1, 1, 0);
    expect_period(8, "R7");
  endtask

  task automatic t_restart;
    program_rate(0, 2, 3);
    put_addr(8'h0C);
    repeat (7) @(negedge clk);
    put_data(8'h03);
    expect_period(18, "R6");
  endtask

  task automatic t_unused;
    logic [7:0] v;
    put_addr(8'h0F);
    put_data(8'hFF);
    get_reg(8'h0F, v); check(v == 8'h00, "R8", v, 0);
    get_reg(8'h0B, v); check(v == 8'h00, "R8", v, 0);
    get_reg(8'h0D, v); check(v == 8'h04, "R8", v, 8'h04);
    get_reg(8'h0C, v); check(v == 8'h03, "R8", v, 8'h03);
    get_reg(8'h0E, v); check(v == 8'h01, "R8", v, 1);
  endtask

  task automatic t_rdata_hold;
    logic [7:0] v;
    get_reg(8'h0D, v);
    put_addr(8'h0C);
    put_data(8'h07);
    repeat (5) @(negedge clk);
    check(rdata == 8'h04, "R10", rdata, 8'h04);
  endtask

  task automatic t_disable;
    logic [7:0] v;
    put_addr(8'h0E);
    put_data(8'h00);
    quiet_for(200, "R5");
    get_reg(8'h0E, v); check(v == 8'h00, "R5", v, 0);
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    addr_we = 1'b0;
    data_we = 1'b0;
    data_rd = 1'b0;
    wdata   = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_disabled;
    t_enable;
    t_nominal;
    t_max_pre;
    t_mid;
    t_div_high;
    t_zero_div;
    t_restart;
    t_unused;
    t_rdata_hold;
    t_disable;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule